// File: doc/BRIEF.md
# Keyed-Radio Frame Transmit Sequencer

This block feeds one frame at a time from a byte buffer to a byte-serial modem and owns the push-to-talk (PTT) line. A start strobe keys the transmitter and opens a preamble. The preamble is a number of byte-times in which no data is presented, and the modem fills that time with its own idle pattern. After the preamble the payload bytes go out, followed by a two-byte frame check sequence (FCS). A tail of further byte-times follows, and then PTT is released. Every step advances on a strobe from the modem that says it can take the next byte. Flag and bit-stuffing generation are left to the modem.

The preamble and tail lengths are derived from the configured bit rate and from delays given in milliseconds. When another frame is already waiting at the end of a frame, the full preamble is skipped. In hold mode, a long hold time in seconds is added to the tail. The frame store sits outside the block. It presents the oldest pending frame through a length, a marker byte at offset 0 and an asynchronous read port. The block pulses `frame_done` when it no longer needs that frame. Recommended configuration values are in the package: 9600 bit/s, 300 ms preamble, 10 ms tail and 10 s hold.

Top module: `radio_tx_seq`

## Requirements
- R1: While reset is held and after its release, `idle`=1, `ptt`=0, `tx_valid`=0 and `frame_done`=0.
- R2: A start strobe in the idle state raises `ptt` on the next cycle and loads a preamble count of floor(bit_rate*txd_ms/8000), or 1 when txd_ms is 0. Each ready strobe then decrements the count. The preamble ends on the strobe that finds the count at 1 or below.
- R3: When the preamble ends and `frame_pending` is 0, `ptt` falls and `idle` rises one cycle after that strobe.
- R4: When the preamble ends on a frame whose marker byte (offset 0) is nonzero, or whose payload length (frame_len-1) is below 2 or at least MAX_FRAME, the frame is dropped. No byte is emitted, `frame_done` pulses one cycle after the strobe, and the next strobe checks the next frame.
- R5: For a frame that is accepted, each ready strobe emits the payload byte at buffer offset 1, 2, ... frame_len-1 in order on `tx_byte`, with a one-cycle `tx_valid` one cycle after the strobe. `rd_addr` addresses that byte.
- R6: The two strobes after the payload emit the FCS. The FCS is CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF over the payload, complemented, low byte first. For payload "123456789" the bytes are 0x6E then 0x90.
- R7: `frame_done` pulses for exactly one cycle, one cycle after the strobe that emits the last payload byte.
- R8: If `frame_pending` is 1 at the strobe that emits the second FCS byte, the preamble count is 1. The next frame's first byte then follows on the second strobe after that one.
- R9: Otherwise the tail count is floor(bit_rate*tail_ms/8000). When duplex_mode is 2, floor(bit_rate*hold_s/8) is added, and a total of 0 becomes 1. `ptt` falls and `idle` rises one cycle after the strobe that finds the count at 1 or below.
- R10: A start strobe during the tail re-enters the preamble with a count of 1 and keeps `ptt` high. This start wins over a ready strobe in the same cycle. A start strobe is ignored while in the preamble, payload or FCS states.
- R11: Ready strobes while idle have no effect: `idle` stays 1 and nothing is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request to key up and send, one-cycle strobe |
| byte_rdy | input | 1 | Modem ready for the next byte, one-cycle strobe |
| frame_pending | input | 1 | The buffer holds at least one frame |
| frame_len | input | LEN_W | Length of the oldest frame, marker byte included |
| frame_first | input | 8 | Marker byte at offset 0 of the oldest frame |
| rd_addr | output | LEN_W | Byte offset read from the oldest frame |
| rd_data | input | 8 | Byte at `rd_addr`, same cycle |
| bit_rate | input | RATE_W | Bit rate in bit/s |
| txd_ms | input | MS_W | Preamble time in ms |
| tail_ms | input | MS_W | Tail time in ms |
| hold_s | input | HOLD_W | Extra hold in seconds (mode 2) |
| duplex_mode | input | 2 | Duplex mode; 2 adds the hold time |
| tx_byte | output | 8 | Byte to the modem |
| tx_valid | output | 1 | `tx_byte` is new this cycle |
| ptt | output | 1 | Push-to-talk |
| idle | output | 1 | Sequencer is off |
| frame_done | output | 1 | Oldest frame released by the block |

## Verification
Two events can collide in one cycle. A start strobe can arrive in the same cycle as a ready strobe while the tail is running. A strobe that would have ended the tail then meets a request to send again. The bench raises both inputs together several strobes into a tail. It then expects `ptt` to stay high and exactly one strobe of preamble before the block goes idle. A second overlap arises when a frame's release pulse is followed by the end-of-frame decision. There the bench checks that the pending flag read at the second FCS byte already reflects the released frame.

// File: rtl/rtx_pkg.sv
// Shared definitions for the keyed-radio transmit sequencer.
// Assumes: state codes are fixed at 0..5 so that observers can decode them.
package rtx_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_HEAD = 3'd1,
        ST_DATA = 3'd2,
        ST_CRC1 = 3'd3,
        ST_CRC2 = 3'd4,
        ST_TAIL = 3'd5
    } tx_state_e;

    // Recommended power-up configuration for the integrating register block
    localparam int unsigned DEF_BIT_RATE = 9600;
    localparam int unsigned DEF_TXD_MS   = 300;
    localparam int unsigned DEF_TAIL_MS  = 10;
    localparam int unsigned DEF_HOLD_S   = 10;

    localparam logic [1:0]  MODE_HOLD = 2'd2;
    localparam logic [15:0] FCS_INIT  = 16'hFFFF;
    localparam logic [15:0] FCS_POLY  = 16'h8408;

    // One byte of the reflected CRC-16, least significant bit first
    function automatic logic [15:0] fcs_step(input logic [15:0] crc, input logic [7:0] din);
        logic [15:0] r;
        r = crc ^ {8'h00, din};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ FCS_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rtx_count_calc.sv
// Converts bit rate and delay settings into byte-time counts.
// Assumes: bit_rate*delay fits in 32 bits; the results are latched by the
// sequencer on state entry, so this path only has to settle within a cycle.
module rtx_count_calc
    import rtx_pkg::*;
#(
    parameter int RATE_W = 20,
    parameter int MS_W   = 12,
    parameter int HOLD_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic [RATE_W-1:0] bit_rate,
    input  logic [MS_W-1:0]   txd_ms,
    input  logic [MS_W-1:0]   tail_ms,
    input  logic [HOLD_W-1:0] hold_s,
    input  logic [1:0]        duplex_mode,
    output logic [CNT_W-1:0]  head_cnt,
    output logic [CNT_W-1:0]  tail_cnt
);
    localparam int PROD_W       = 32;
    localparam int MS_BYTE_DIV  = 8000;   // 8 bits per byte * 1000 ms per s
    localparam int BITS_PER_BYTE = 8;

    logic [PROD_W-1:0] head_prod, tail_prod, hold_prod;
    logic [PROD_W-1:0] head_q, tail_q, hold_q, tail_sum;

    // Preamble length: forced to one byte-time when no delay is configured
    always_comb begin
        head_prod = PROD_W'(bit_rate) * PROD_W'(txd_ms);
        head_q    = head_prod / PROD_W'(MS_BYTE_DIV);
        head_cnt  = (txd_ms == '0) ? CNT_W'(1) : CNT_W'(head_q);
    end

    // Tail length, with the hold time added in hold mode, never below one
    always_comb begin
        tail_prod = PROD_W'(bit_rate) * PROD_W'(tail_ms);
        hold_prod = PROD_W'(bit_rate) * PROD_W'(hold_s);
        tail_q    = tail_prod / PROD_W'(MS_BYTE_DIV);
        hold_q    = hold_prod / PROD_W'(BITS_PER_BYTE);
        tail_sum  = (duplex_mode == MODE_HOLD) ? (tail_q + hold_q) : tail_q;
        tail_cnt  = (tail_sum == '0) ? CNT_W'(1) : CNT_W'(tail_sum);
    end

endmodule

// File: rtl/rtx_fcs16.sv
// Running CRC-16 register over the payload bytes.
// Assumes: clr and en are never both set; clr has priority if they are.
module rtx_fcs16
    import rtx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    // Hold the running remainder; restart on clr, fold one byte on en
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= FCS_INIT;
        else if (clr) crc <= FCS_INIT;
        else if (en)  crc <= fcs_step(crc, din);
    end

    // R6
    fcs_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == FCS_INIT));

endmodule

// File: rtl/rtx_frame_check.sv
// Decides whether the oldest buffered frame may be sent.
// Assumes: frame_len counts the marker byte at offset 0.
module rtx_frame_check #(
    parameter int LEN_W     = 11,
    parameter int MAX_FRAME = 1024
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic [7:0]       frame_first,
    output logic             frame_ok,
    output logic [LEN_W-1:0] payload_len
);
    localparam int MIN_PAYLOAD = 2;

    // Payload excludes the marker; accept data frames of sane length only
    always_comb begin
        payload_len = frame_len - LEN_W'(1);
        frame_ok    = (frame_first == 8'h00)
                   && (int'(frame_len) >= MIN_PAYLOAD + 1)
                   && (int'(payload_len) < MAX_FRAME);
    end

endmodule

// File: rtl/radio_tx_seq.sv
// Frame transmit sequencer: keys PTT, counts preamble byte-times, streams
// payload and FCS, counts tail byte-times, then unkeys.
// Assumes: rd_data follows rd_addr in the same cycle; frame_pending reflects
// a frame_done pulse before the next byte_rdy strobe.
module radio_tx_seq
    import rtx_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int MAX_FRAME = 1024,
    parameter int RATE_W    = 20,
    parameter int MS_W      = 12,
    parameter int HOLD_W    = 8,
    parameter int CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              byte_rdy,
    input  logic              frame_pending,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [7:0]        frame_first,
    output logic [LEN_W-1:0]  rd_addr,
    input  logic [7:0]        rd_data,
    input  logic [RATE_W-1:0] bit_rate,
    input  logic [MS_W-1:0]   txd_ms,
    input  logic [MS_W-1:0]   tail_ms,
    input  logic [HOLD_W-1:0] hold_s,
    input  logic [1:0]        duplex_mode,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    output logic              ptt,
    output logic              idle,
    output logic              frame_done
);
    tx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] idx, plen_q, payload_len;
    logic [CNT_W-1:0] head_cnt, tail_cnt;
    logic [15:0]      crc;
    logic             frame_ok, cnt_expired, last_byte, fcs_clr, fcs_en;
    logic             ptt_q, valid_q, done_q;
    logic [7:0]       byte_q;

    rtx_count_calc #(
        .RATE_W(RATE_W), .MS_W(MS_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W)
    ) u_cnt (
        .bit_rate(bit_rate), .txd_ms(txd_ms), .tail_ms(tail_ms),
        .hold_s(hold_s), .duplex_mode(duplex_mode),
        .head_cnt(head_cnt), .tail_cnt(tail_cnt)
    );

    rtx_frame_check #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_chk (
        .frame_len(frame_len), .frame_first(frame_first),
        .frame_ok(frame_ok), .payload_len(payload_len)
    );

    rtx_fcs16 u_fcs (
        .clk(clk), .rst_n(rst_n), .clr(fcs_clr), .en(fcs_en),
        .din(rd_data), .crc(crc)
    );

    // Decode count expiry, last payload byte and FCS control
    always_comb begin
        cnt_expired = (cnt <= CNT_W'(1));
        last_byte   = ((idx + LEN_W'(1)) == plen_q);
        rd_addr     = idx + LEN_W'(1);
        fcs_clr     = (state == ST_HEAD) && byte_rdy && cnt_expired
                      && frame_pending && frame_ok;
        fcs_en      = (state == ST_DATA) && byte_rdy;
    end

    // Sequencer: one step per ready strobe; start handled only in OFF and TAIL
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            cnt     <= '0;
            idx     <= '0;
            plen_q  <= '0;
            ptt_q   <= 1'b0;
            byte_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            unique case (state)
                ST_OFF: begin
                    if (start_req) begin
                        state <= ST_HEAD;
                        cnt   <= head_cnt;
                        ptt_q <= 1'b1;
                    end
                end
                ST_HEAD: begin
                    if (byte_rdy) begin
                        if (!cnt_expired) begin
                            cnt <= cnt - CNT_W'(1);
                        end else if (!frame_pending) begin
                            state <= ST_OFF;
                            ptt_q <= 1'b0;
                        end else if (!frame_ok) begin
                            done_q <= 1'b1;
                            cnt    <= CNT_W'(1);
                        end else begin
                            plen_q <= payload_len;
                            idx    <= '0;
                            state  <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (byte_rdy) begin
                        byte_q  <= rd_data;
                        valid_q <= 1'b1;
                        idx     <= idx + LEN_W'(1);
                        if (last_byte) begin
                            state  <= ST_CRC1;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_CRC1: begin
                    if (byte_rdy) begin
                        byte_q  <= ~crc[7:0];
                        valid_q <= 1'b1;
                        state   <= ST_CRC2;
                    end
                end
                ST_CRC2: begin
                    if (byte_rdy) begin
                        byte_q  <= ~crc[15:8];
                        valid_q <= 1'b1;
                        if (frame_pending) begin
                            state <= ST_HEAD;
                            cnt   <= CNT_W'(1);
                        end else begin
                            state <= ST_TAIL;
                            cnt   <= tail_cnt;
                        end
                    end
                end
                ST_TAIL: begin
                    if (start_req) begin
                        state <= ST_HEAD;
                        cnt   <= CNT_W'(1);
                    end else if (byte_rdy) begin
                        if (cnt_expired) begin
                            state <= ST_OFF;
                            ptt_q <= 1'b0;
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                end
                default: state <= ST_OFF;
            endcase
        end
    end

    // Drive the registered outputs
    always_comb begin
        tx_byte    = byte_q;
        tx_valid   = valid_q;
        ptt        = ptt_q;
        idle       = (state == ST_OFF);
        frame_done = done_q;
    end

    // R1
    idle_unkeyed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !ptt);

    // R5
    valid_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(byte_rdy));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R10
    ptt_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ptt) |-> $past(start_req));

    // R11
    off_rdy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && byte_rdy && !start_req) |=> (idle && !tx_valid));

endmodule

// File: tb/radio_tx_seq_tb.sv
module radio_tx_seq_tb;
    localparam int LEN_W = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0, byte_rdy = 1'b0;
    logic        frame_pending = 1'b0;
    logic [10:0] frame_len = '0;
    logic [7:0]  frame_first = '0;
    logic [10:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic [19:0] bit_rate = 20'd9600;
    logic [11:0] txd_ms = 12'd10, tail_ms = 12'd10;
    logic [7:0]  hold_s = 8'd10;
    logic [1:0]  duplex_mode = 2'd0;
    logic [7:0]  tx_byte;
    logic        tx_valid, ptt, idle, frame_done;

    always #5 clk = ~clk;

    radio_tx_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .byte_rdy(byte_rdy),
        .frame_pending(frame_pending), .frame_len(frame_len),
        .frame_first(frame_first), .rd_addr(rd_addr), .rd_data(rd_data),
        .bit_rate(bit_rate), .txd_ms(txd_ms), .tail_ms(tail_ms),
        .hold_s(hold_s), .duplex_mode(duplex_mode), .tx_byte(tx_byte),
        .tx_valid(tx_valid), .ptt(ptt), .idle(idle), .frame_done(frame_done)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // frame ring held by the bench
    logic [7:0] fmem [0:7][0:15];
    int flen [0:7];
    int qh = 0, qt = 0, last_slot = 0;

    task automatic push_frame(input int len);
        for (int i = 0; i < 16; i++) fmem[qt][i] = 8'h00;
        flen[qt] = len;
        last_slot = qt;
        qt = (qt + 1) % 8;
    endtask

    task automatic put(input int i, input logic [7:0] v);
        fmem[last_slot][i] = v;
    endtask

    // behavioural reference model
    int     m_state = 0;
    longint m_cnt = 0;
    int     m_idx = 0, m_plen = 0;
    bit     m_ptt = 0, m_valid = 0, m_done = 0;
    logic [7:0]  m_byte = 0;
    logic [15:0] m_crc = 16'hFFFF;

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            0: return "R11";
            1: return "R2";
            2: return "R5";
            3, 4: return "R6";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_idx = 0; m_ptt = 0; m_valid = 0; m_done = 0;
            m_crc = 16'hFFFF;
        end else begin
            m_valid = 0; m_done = 0;
            case (m_state)
                0: if (start_req) begin
                       m_state = 1; m_ptt = 1;
                       m_cnt = (txd_ms == 0) ? 1 : (longint'(bit_rate) * txd_ms) / 8000;
                   end
                1: if (byte_rdy) begin
                       if (m_cnt > 1) m_cnt--;
                       else if (!frame_pending) begin m_state = 0; m_ptt = 0; end
                       else if (frame_first != 0 || frame_len < 3 || frame_len - 1 >= 1024) begin
                           m_done = 1; m_cnt = 1;
                       end else begin
                           m_plen = frame_len - 1; m_idx = 0; m_crc = 16'hFFFF; m_state = 2;
                       end
                   end
                2: if (byte_rdy) begin
                       m_byte = (m_idx + 1 < 16) ? fmem[qh][m_idx + 1] : 8'h00;
                       m_valid = 1;
                       m_crc = crc_byte(m_crc, m_byte);
                       m_idx++;
                       if (m_idx == m_plen) begin m_state = 3; m_done = 1; end
                   end
                3: if (byte_rdy) begin m_byte = ~m_crc[7:0]; m_valid = 1; m_state = 4; end
                4: if (byte_rdy) begin
                       m_byte = ~m_crc[15:8]; m_valid = 1;
                       if (frame_pending) begin m_state = 1; m_cnt = 1; end
                       else begin
                           m_cnt = (longint'(bit_rate) * tail_ms) / 8000;
                           if (duplex_mode == 2) m_cnt += (longint'(bit_rate) * hold_s) / 8;
                           if (m_cnt == 0) m_cnt = 1;
                           m_state = 5;
                       end
                   end
                default: if (start_req) begin m_state = 1; m_cnt = 1; end
                   else if (byte_rdy) begin
                       if (m_cnt <= 1) begin m_state = 0; m_ptt = 0; end
                       else m_cnt--;
                   end
            endcase
        end
    end

    // lockstep comparison, frame release and buffer port drive at negedge
    int done_cnt = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(ptt == m_ptt, tag_of(m_state), "ptt", ptt, m_ptt);
            check(idle == (m_state == 0), tag_of(m_state), "idle", idle, m_state == 0);
            check(tx_valid == m_valid, tag_of(m_state), "tx_valid", tx_valid, m_valid);
            if (m_valid) check(tx_byte == m_byte, tag_of(m_state), "tx_byte", tx_byte, m_byte);
            check(frame_done == m_done, "R7", "frame_done", frame_done, m_done);
            if (frame_done) done_cnt++;
        end
        if (m_done) qh = (qh + 1) % 8;
        frame_pending = (qh != qt);
        frame_len     = (qh != qt) ? 11'(flen[qh]) : 11'd0;
        frame_first   = fmem[qh][0];
        rd_data       = (rd_addr < 16) ? fmem[qh][rd_addr[3:0]] : 8'h00;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    // strobe log
    logic [7:0] lg_byte [0:63];
    int lg_at [0:63];
    int lg_n = 0, nstrobe = 0, first_idle = 0;

    task automatic clear_log();
        lg_n = 0; nstrobe = 0; first_idle = 0; done_cnt = 0;
    endtask

    task automatic strobe(input bit with_start);
        @(negedge clk);
        byte_rdy = 1'b1; start_req = with_start;
        @(negedge clk);
        byte_rdy = 1'b0; start_req = 1'b0;
        nstrobe++;
        if (tx_valid && lg_n < 64) begin
            lg_byte[lg_n] = tx_byte; lg_at[lg_n] = nstrobe; lg_n++;
        end
        if (idle && first_idle == 0) first_idle = nstrobe;
        @(negedge clk);
    endtask

    task automatic start_pulse();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int s = 0; s < 8; s++) begin
            flen[s] = 0;
            for (int i = 0; i < 16; i++) fmem[s][i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(idle == 1 && ptt == 0 && tx_valid == 0 && frame_done == 0, "R1",
              "reset outputs", {idle, ptt, tx_valid, frame_done}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(idle == 1 && ptt == 0, "R1", "after release", {idle, ptt}, 2'b10);

        // frame with payload "123456789", 12-byte preamble and tail
        push_frame(10);
        put(0, 8'h00);
        for (int i = 1; i <= 9; i++) put(i, 8'h30 + 8'(i));
        settle();
        clear_log();
        start_pulse();
        check(ptt == 1, "R2", "ptt after start", ptt, 1);
        while (!idle && nstrobe < 100) strobe(0);
        check(lg_n == 11, "R5", "bytes sent", lg_n, 11);
        check(lg_at[0] == 13, "R2", "first byte strobe", lg_at[0], 13);
        check(lg_byte[9] == 8'h6E && lg_byte[10] == 8'h90, "R6", "fcs bytes",
              {lg_byte[9], lg_byte[10]}, 16'h6E90);
        check(first_idle == 35, "R9", "tail end strobe", first_idle, 35);
        check(done_cnt == 1, "R7", "done pulses", done_cnt, 1);

        // R3: start without frames, no preamble delay
        txd_ms = 12'd0;
        settle();
        clear_log();
        start_pulse();
        strobe(0);
        check(idle == 1 && ptt == 0, "R3", "empty key-up", {idle, ptt}, 2'b10);

        // R4: three frames rejected
        push_frame(4); put(0, 8'h05); put(1, 8'h11); put(2, 8'h22); put(3, 8'h33);
        push_frame(2); put(0, 8'h00); put(1, 8'h44);
        push_frame(1025); put(0, 8'h00);
        settle();
        clear_log();
        start_pulse();
        while (!idle && nstrobe < 20) strobe(0);
        check(lg_n == 0, "R4", "bytes from rejected frames", lg_n, 0);
        check(done_cnt == 3, "R4", "rejections", done_cnt, 3);
        check(first_idle == 4, "R4", "idle strobe", first_idle, 4);

        // R8: back-to-back frames, stray start mid-frame (R10)
        push_frame(3); put(0, 8'h00); put(1, 8'hA1); put(2, 8'hA2);
        push_frame(4); put(0, 8'h00); put(1, 8'hC1); put(2, 8'hC2); put(3, 8'hC3);
        settle();
        clear_log();
        start_pulse();
        strobe(0); strobe(0);
        start_pulse();
        while (!idle && nstrobe < 100) strobe(0);
        check(lg_n == 9, "R8", "bytes sent", lg_n, 9);
        check(lg_byte[4] == 8'hC1 && lg_at[4] == 7, "R8", "second frame start strobe",
              lg_at[4], 7);
        check(lg_byte[1] == 8'hA2, "R10", "start ignored in data", lg_byte[1], 8'hA2);

        // R11: strobes while idle
        clear_log();
        strobe(0); strobe(0); strobe(0);
        check(idle == 1 && lg_n == 0, "R11", "idle strobes", {idle, 8'(lg_n)}, 9'h100);

        // R10: start together with a tail strobe
        push_frame(3); put(0, 8'h00); put(1, 8'h01); put(2, 8'h02);
        settle();
        clear_log();
        start_pulse();
        for (int k = 0; k < 8; k++) strobe(0);
        check(ptt == 1 && idle == 0, "R10", "in tail", {ptt, idle}, 2'b10);
        strobe(1);
        check(ptt == 1 && idle == 0, "R10", "restart keeps ptt", {ptt, idle}, 2'b10);
        strobe(0);
        check(idle == 1 && ptt == 0, "R10", "one preamble strobe then off", {idle, ptt}, 2'b10);

        // R9: hold mode tail = 12 + 1200
        duplex_mode = 2'd2; hold_s = 8'd1;
        push_frame(3); put(0, 8'h00); put(1, 8'h07); put(2, 8'h08);
        settle();
        clear_log();
        start_pulse();
        while (!idle && nstrobe < 2000) strobe(0);
        check(first_idle == 1217, "R9", "hold tail end strobe", first_idle, 1217);

        settle();
        report();
    end

endmodule